// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block produces the digital drive waveforms for a three-colour linear CCD image sensor. A line starts with a transfer phase. The first shift clock is held in its active level for a guard interval, the transfer gate pulses for a programmed width, and a second guard interval follows. The pixel train comes next: the two shift-register clocks swap level once per pixel for a programmed number of pixels. Through both phases a pixel divider issues one reset-gate pulse and one clamp pulse per pixel period. The clamp pulse comes after the reset pulse, inside the same period.

During the pixel train the block drives a pixel index and a region tag for the sample currently being shifted out, so a downstream capture stage can separate dummy, dark-reference, image and overscan samples. A one-clock strobe marks the falling edge of the transfer gate. All durations are integer counts of the system clock. They are taken from configuration inputs while reset is held. Any configuration that cannot produce a legal line raises an error flag, and the generator then refuses to start. Lines repeat back to back after a start request. A stop request ends operation at the next line boundary.

Top module: `ccd_drive_gen`

## Requirements
- R1: Configuration is sampled on every clock while `rst` is high. `err_o` is 1 when the pixel count per line is below the minimum (N_INV_A+N_OB+N_INV_B+N_VALID+N_TAIL, 10669 by default), when the divider is below RG_W+CLB_GAP+CLB_W, or when the guard or gate width is zero. While `err_o` is 1, `start_i` has no effect and every output keeps its idle level.
- R2: After reset and while idle: `tg_o`=0, `phi1_o`=1, `phi2_o`=0, `rg_o`=0, `clb_o`=0, `pix_vld_o`=0, `pix_o`=0, `tag_o`=0, `line_start_o`=0.
- R3: Each line begins with `cfg_guard_i` clocks with the gate low, then exactly `cfg_tgw_i` clocks with `tg_o`=1, then `cfg_guard_i` clocks with the gate low. `phi1_o` stays 1 for this whole transfer phase.
- R4: `phi2_o` is the complement of `phi1_o` on every cycle.
- R5: Whenever the generator is not idle, a pixel period of `cfg_div_i` clocks repeats. `rg_o` is 1 for the first RG_W clocks of the period. `clb_o` is 1 for CLB_W clocks starting RG_W+CLB_GAP clocks into the period. The two never overlap. The pulses continue through the transfer phase, and the period restarts at the first clock of the pixel train.
- R6: The pixel train has `cfg_line_i` pixels of `cfg_div_i` clocks each. `pix_vld_o`=1 and `pix_o` counts from 0 to `cfg_line_i`-1. `phi1_o` is 0 on even indices and 1 on odd ones, so it changes once per pixel.
- R7: `tag_o` encoding is 0 = dummy, 1 = dark reference, 2 = image, 3 = overscan. Indices below N_INV_A are dummy. The next N_OB are dark reference. The next N_INV_B are dummy. The next N_VALID are image. All remaining indices are overscan. `tag_o` is 0 whenever `pix_vld_o` is 0.
- R8: `line_start_o` is 1 for exactly the one clock after `tg_o` falls, and at no other time.
- R9: After a start, lines follow each other with no gap. A stop request is held until the last pixel of the current line and then returns the block to idle. A start while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; configuration is loaded while high |
| cfg_div_i | input | DW | Clocks per pixel period |
| cfg_guard_i | input | CW | Clocks of first-shift-clock hold before and after the gate pulse |
| cfg_tgw_i | input | CW | Transfer gate pulse width in clocks |
| cfg_line_i | input | CW | Pixels per line in the pixel train |
| start_i | input | 1 | Start request, acted on while idle |
| stop_i | input | 1 | Stop request, acted on at the end of a line |
| tg_o | output | 1 | Transfer gate clock |
| phi1_o | output | 1 | Shift-register clock 1 |
| phi2_o | output | 1 | Shift-register clock 2 |
| rg_o | output | 1 | Reset-gate pulse |
| clb_o | output | 1 | Clamp pulse |
| pix_vld_o | output | 1 | Pixel train active |
| pix_o | output | CW | Index of the pixel being shifted out |
| tag_o | output | 2 | Region tag of the current pixel |
| line_start_o | output | 1 | One-clock strobe after the gate falls |
| err_o | output | 1 | Loaded configuration is illegal |

## Verification
The checker watches, on every cycle, the relations that hold locally in time. These are: the shift clocks are complementary; clock 1 is active while the gate is high; the reset and clamp pulses never overlap; the strobe coincides with the gate's fall; the pixel index steps by one from zero with clock 1 flipping at each step; the tag is quiet outside the train; nothing moves while the error flag is set. Exact phase lengths, pulse placement within the pixel period, region boundaries, deferral of stop to the line end, and the rejection of each illegal configuration depend on counts across many cycles. The bench's cycle-accurate reference model shows these, together with scenario checks on gate width, line count and final index.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_GATE  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_TRAIN = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        TAG_INV  = 2'd0,
        TAG_DARK = 2'd1,
        TAG_IMG  = 2'd2,
        TAG_OVER = 2'd3
    } tag_e;

endpackage

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
    parameter int DW      = 8,
    parameter int RG_W    = 2,
    parameter int CLB_GAP = 1,
    parameter int CLB_W   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic [DW-1:0] div_i,
    output logic          per_end_o,
    output logic          rg_o,
    output logic          clb_o
);

    localparam logic [DW-1:0] RG_END  = DW'(RG_W);
    localparam logic [DW-1:0] CLB_BEG = DW'(RG_W + CLB_GAP);
    localparam logic [DW-1:0] CLB_END = DW'(RG_W + CLB_GAP + CLB_W);

    typedef struct packed {
        logic [DW-1:0] pc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign per_end_o = (tmr_q.pc == (div_i - DW'(1)));

    always_comb begin
        tmr_d = tmr_q;
        if (rst || !run_i || restart_i || per_end_o) begin
            tmr_d.pc = '0;
        end else begin
            tmr_d.pc = tmr_q.pc + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign rg_o  = run_i && (tmr_q.pc < RG_END);
    assign clb_o = run_i && (tmr_q.pc >= CLB_BEG) && (tmr_q.pc < CLB_END);

endmodule

// File: rtl/ccd_region_map.sv
module ccd_region_map
    import ccd_pkg::*;
#(
    parameter int CW      = 16,
    parameter int N_INV_A = 3,
    parameter int N_OB    = 49,
    parameter int N_INV_B = 2,
    parameter int N_VALID = 10600
) (
    input  logic [CW-1:0] pix_i,
    input  logic          vld_i,
    output tag_e          tag_o
);

    localparam logic [CW-1:0] B_DARK = CW'(N_INV_A);
    localparam logic [CW-1:0] B_GAP  = CW'(N_INV_A + N_OB);
    localparam logic [CW-1:0] B_IMG  = CW'(N_INV_A + N_OB + N_INV_B);
    localparam logic [CW-1:0] B_OVER = CW'(N_INV_A + N_OB + N_INV_B + N_VALID);

    always_comb begin
        if (!vld_i || pix_i < B_DARK) begin
            tag_o = TAG_INV;
        end else if (pix_i < B_GAP) begin
            tag_o = TAG_DARK;
        end else if (pix_i < B_IMG) begin
            tag_o = TAG_INV;
        end else if (pix_i < B_OVER) begin
            tag_o = TAG_IMG;
        end else begin
            tag_o = TAG_OVER;
        end
    end

endmodule

// File: rtl/ccd_drive_gen.sv
module ccd_drive_gen
    import ccd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CW      = 16,
    parameter int RG_W    = 2,
    parameter int CLB_GAP = 1,
    parameter int CLB_W   = 1,
    parameter int N_INV_A = 3,
    parameter int N_OB    = 49,
    parameter int N_INV_B = 2,
    parameter int N_VALID = 10600,
    parameter int N_TAIL  = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] cfg_div_i,
    input  logic [CW-1:0] cfg_guard_i,
    input  logic [CW-1:0] cfg_tgw_i,
    input  logic [CW-1:0] cfg_line_i,
    input  logic          start_i,
    input  logic          stop_i,
    output logic          tg_o,
    output logic          phi1_o,
    output logic          phi2_o,
    output logic          rg_o,
    output logic          clb_o,
    output logic          pix_vld_o,
    output logic [CW-1:0] pix_o,
    output logic [1:0]    tag_o,
    output logic          line_start_o,
    output logic          err_o
);

    localparam int            PIX_MIN   = N_INV_A + N_OB + N_INV_B + N_VALID + N_TAIL;
    localparam logic [CW-1:0] PIX_MIN_C = CW'(PIX_MIN);
    localparam logic [DW-1:0] SPAN_C    = DW'(RG_W + CLB_GAP + CLB_W);
    localparam logic [CW-1:0] ONE_C     = CW'(1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] pix;
        logic [DW-1:0] div;
        logic [CW-1:0] guard;
        logic [CW-1:0] tgw;
        logic [CW-1:0] line;
        logic          err;
        logic          pend;
        logic          ls;
    } seq_t;

    seq_t seq_d, seq_q;
    logic restart_w;
    logic per_end_w;
    logic run_w;
    logic train_w;
    tag_e tag_w;

    assign run_w   = (seq_q.st != ST_IDLE);
    assign train_w = (seq_q.st == ST_TRAIN);

    ccd_pix_timer #(
        .DW      (DW),
        .RG_W    (RG_W),
        .CLB_GAP (CLB_GAP),
        .CLB_W   (CLB_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_w),
        .restart_i (restart_w),
        .div_i     (seq_q.div),
        .per_end_o (per_end_w),
        .rg_o      (rg_o),
        .clb_o     (clb_o)
    );

    ccd_region_map #(
        .CW      (CW),
        .N_INV_A (N_INV_A),
        .N_OB    (N_OB),
        .N_INV_B (N_INV_B),
        .N_VALID (N_VALID)
    ) u_region (
        .pix_i (seq_q.pix),
        .vld_i (train_w),
        .tag_o (tag_w)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.ls  = 1'b0;
        restart_w = 1'b0;
        if (rst) begin
            seq_d.st    = ST_IDLE;
            seq_d.cnt   = '0;
            seq_d.pix   = '0;
            seq_d.div   = cfg_div_i;
            seq_d.guard = cfg_guard_i;
            seq_d.tgw   = cfg_tgw_i;
            seq_d.line  = cfg_line_i;
            seq_d.err   = (cfg_line_i < PIX_MIN_C) || (cfg_div_i < SPAN_C) ||
                          (cfg_guard_i == '0) || (cfg_tgw_i == '0);
            seq_d.pend  = 1'b0;
        end else begin
            if (stop_i && run_w) begin
                seq_d.pend = 1'b1;
            end
            case (seq_q.st)
                ST_IDLE: begin
                    seq_d.pend = 1'b0;
                    if (start_i && !seq_q.err) begin
                        seq_d.st  = ST_LEAD;
                        seq_d.cnt = '0;
                    end
                end
                ST_LEAD: begin
                    if (seq_q.cnt == seq_q.guard - ONE_C) begin
                        seq_d.st  = ST_GATE;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE_C;
                    end
                end
                ST_GATE: begin
                    if (seq_q.cnt == seq_q.tgw - ONE_C) begin
                        seq_d.st  = ST_TRAIL;
                        seq_d.cnt = '0;
                        seq_d.ls  = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE_C;
                    end
                end
                ST_TRAIL: begin
                    if (seq_q.cnt == seq_q.guard - ONE_C) begin
                        seq_d.st  = ST_TRAIN;
                        seq_d.cnt = '0;
                        seq_d.pix = '0;
                        restart_w = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + ONE_C;
                    end
                end
                ST_TRAIN: begin
                    if (per_end_w) begin
                        if (seq_q.pix == seq_q.line - ONE_C) begin
                            seq_d.pix = '0;
                            if (seq_q.pend || stop_i) begin
                                seq_d.st   = ST_IDLE;
                                seq_d.pend = 1'b0;
                            end else begin
                                seq_d.st = ST_LEAD;
                            end
                        end else begin
                            seq_d.pix = seq_q.pix + ONE_C;
                        end
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign tg_o         = (seq_q.st == ST_GATE);
    assign phi1_o       = train_w ? seq_q.pix[0] : 1'b1;
    assign phi2_o       = train_w ? ~seq_q.pix[0] : 1'b0;
    assign pix_vld_o    = train_w;
    assign pix_o        = train_w ? seq_q.pix : '0;
    assign tag_o        = tag_w;
    assign line_start_o = seq_q.ls;
    assign err_o        = seq_q.err;

endmodule

// File: rtl/ccd_drive_chk.sv
module ccd_drive_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tg_o,
    input logic          phi1_o,
    input logic          phi2_o,
    input logic          rg_o,
    input logic          clb_o,
    input logic          pix_vld_o,
    input logic [CW-1:0] pix_o,
    input logic [1:0]    tag_o,
    input logic          line_start_o,
    input logic          err_o
);

    AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!tg_o && !pix_vld_o && !rg_o && !clb_o && phi1_o)); // R1

    AST_GATE_HOLDS_PHI1: assert property (@(posedge clk) disable iff (rst)
        tg_o |-> (phi1_o && !pix_vld_o)); // R3

    AST_PHI_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        phi2_o == !phi1_o); // R4

    AST_RG_CLB_APART: assert property (@(posedge clk) disable iff (rst)
        !(rg_o && clb_o)); // R5

    AST_TRAIN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_vld_o) |-> (pix_o == '0)); // R6

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_vld_o && $past(pix_vld_o) && (pix_o != $past(pix_o))) |->
        ((pix_o == $past(pix_o) + CW'(1)) && (phi1_o != $past(phi1_o)))); // R6

    AST_TAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pix_vld_o |-> (tag_o == 2'd0)); // R7

    AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(tg_o) |-> line_start_o); // R8

    AST_STROBE_ONLY_FALL: assert property (@(posedge clk) disable iff (rst)
        line_start_o |-> ($past(tg_o) && !tg_o)); // R8

endmodule

bind ccd_drive_gen ccd_drive_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tg_o         (tg_o),
    .phi1_o       (phi1_o),
    .phi2_o       (phi2_o),
    .rg_o         (rg_o),
    .clb_o        (clb_o),
    .pix_vld_o    (pix_vld_o),
    .pix_o        (pix_o),
    .tag_o        (tag_o),
    .line_start_o (line_start_o),
    .err_o        (err_o)
);

// File: tb/ccd_drive_gen_tb_top.sv
module ccd_drive_gen_tb_top;

    localparam int DW      = 8;
    localparam int CW      = 16;
    localparam int RG_W    = 2;
    localparam int CLB_GAP = 1;
    localparam int CLB_W   = 1;
    localparam int N_INV_A = 3;
    localparam int N_OB    = 8;
    localparam int N_INV_B = 2;
    localparam int N_VALID = 24;
    localparam int N_TAIL  = 15;
    localparam int PIX_MIN = N_INV_A + N_OB + N_INV_B + N_VALID + N_TAIL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] cfg_div = 8'd6;
    logic [CW-1:0] cfg_guard = 16'd3;
    logic [CW-1:0] cfg_tgw = 16'd7;
    logic [CW-1:0] cfg_line = 16'd60;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          tg_o, phi1_o, phi2_o, rg_o, clb_o, pix_vld_o, line_start_o, err_o;
    logic [CW-1:0] pix_o;
    logic [1:0]    tag_o;

    always #10 clk = ~clk;

    ccd_drive_gen #(
        .DW(DW), .CW(CW), .RG_W(RG_W), .CLB_GAP(CLB_GAP), .CLB_W(CLB_W),
        .N_INV_A(N_INV_A), .N_OB(N_OB), .N_INV_B(N_INV_B), .N_VALID(N_VALID), .N_TAIL(N_TAIL)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_div_i(cfg_div), .cfg_guard_i(cfg_guard),
        .cfg_tgw_i(cfg_tgw), .cfg_line_i(cfg_line), .start_i(start), .stop_i(stop),
        .tg_o(tg_o), .phi1_o(phi1_o), .phi2_o(phi2_o), .rg_o(rg_o), .clb_o(clb_o),
        .pix_vld_o(pix_vld_o), .pix_o(pix_o), .tag_o(tag_o),
        .line_start_o(line_start_o), .err_o(err_o)
    );

    // ---------------- reference model ----------------
    int mst = 0, mcnt = 0, mpc = 0, mpix = 0, mdiv = 0, mguard = 0, mtgw = 0, mline = 0;
    bit mpend = 0, mls = 0, merr = 0, mvalid = 0;

    function automatic int tag_of(input int p);
        if (p < N_INV_A) return 0;
        if (p < N_INV_A + N_OB) return 1;
        if (p < N_INV_A + N_OB + N_INV_B) return 0;
        if (p < N_INV_A + N_OB + N_INV_B + N_VALID) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        int  ost;
        bit  pcend;
        bit  rs;
        if (rst) begin
            mst = 0; mcnt = 0; mpc = 0; mpix = 0; mpend = 0; mls = 0;
            mdiv = int'(cfg_div); mguard = int'(cfg_guard);
            mtgw = int'(cfg_tgw); mline = int'(cfg_line);
            merr = (mline < PIX_MIN) || (mdiv < RG_W + CLB_GAP + CLB_W) ||
                   (mguard == 0) || (mtgw == 0);
            mvalid = 1;
        end else begin
            ost   = mst;
            pcend = (mpc == mdiv - 1);
            rs    = 0;
            mls   = 0;
            if (stop && ost != 0) mpend = 1;
            case (ost)
                0: begin
                    mpend = 0;
                    if (start && !merr) begin mst = 1; mcnt = 0; end
                end
                1: if (mcnt == mguard - 1) begin mst = 2; mcnt = 0; end else mcnt++;
                2: if (mcnt == mtgw - 1) begin mst = 3; mcnt = 0; mls = 1; end else mcnt++;
                3: if (mcnt == mguard - 1) begin mst = 4; mcnt = 0; mpix = 0; rs = 1; end else mcnt++;
                default: if (pcend) begin
                    if (mpix == mline - 1) begin
                        mpix = 0;
                        if (mpend || stop) begin mst = 0; mpend = 0; end else mst = 1;
                    end else mpix++;
                end
            endcase
            if (ost == 0 || rs || pcend) mpc = 0; else mpc++;
        end
    end

    int cyc_checks = 0, cyc_errors = 0;

    task automatic chk_c(input string req, input string what, input int act, input int exp);
        cyc_checks++;
        if (act != exp) begin
            cyc_errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mvalid) begin
            bit vld;
            vld = (mst == 4);
            chk_c("R3", "tg_o", int'(tg_o), int'(mst == 2));
            chk_c("R6", "phi1_o", int'(phi1_o), vld ? (mpix % 2) : 1);
            chk_c("R4", "phi2_o", int'(phi2_o), vld ? 1 - (mpix % 2) : 0);
            chk_c("R5", "rg_o", int'(rg_o), int'(mst != 0 && mpc < RG_W));
            chk_c("R5", "clb_o", int'(clb_o),
                  int'(mst != 0 && mpc >= RG_W + CLB_GAP && mpc < RG_W + CLB_GAP + CLB_W));
            chk_c("R6", "pix_vld_o", int'(pix_vld_o), int'(vld));
            chk_c("R6", "pix_o", int'(pix_o), vld ? mpix : 0);
            chk_c("R7", "tag_o", int'(tag_o), vld ? tag_of(mpix) : 0);
            chk_c("R8", "line_start_o", int'(line_start_o), int'(mls));
            chk_c("R1", "err_o", int'(err_o), int'(merr));
        end
    end

    // ---------------- observation monitors ----------------
    int ls_cnt = 0, tg_run = 0, tgw_seen = 0, pmax = 0;
    always @(negedge clk) begin
        if (line_start_o) ls_cnt++;
        if (tg_o) tg_run++;
        else if (tg_run > 0) begin tgw_seen = tg_run; tg_run = 0; end
        if (pix_vld_o && int'(pix_o) > pmax) pmax = int'(pix_o);
    end

    // ---------------- scenarios ----------------
    int s_checks = 0, s_errors = 0;

    task automatic chk_s(input string req, input string what, input int act, input int exp);
        s_checks++;
        if (act != exp) begin
            s_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset(input int d, input int g, input int w, input int l);
        @(negedge clk);
        rst = 1'b1;
        cfg_div = DW'(d); cfg_guard = CW'(g); cfg_tgw = CW'(w); cfg_line = CW'(l);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    initial begin
        int ls0;
        // normal line, reset state
        apply_reset(6, 3, 7, 60);
        chk_s("R2", "idle tg_o", int'(tg_o), 0);
        chk_s("R2", "idle phi1_o", int'(phi1_o), 1);
        chk_s("R2", "idle phi2_o", int'(phi2_o), 0);
        chk_s("R2", "idle rg_o", int'(rg_o), 0);
        chk_s("R2", "idle pix_vld_o", int'(pix_vld_o), 0);
        chk_s("R1", "legal cfg err_o", int'(err_o), 0);
        ls0 = ls_cnt;
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();                 // R9: ignored while running
        repeat (423) @(negedge clk);
        pulse_stop();                  // R9: deferred to line end
        repeat (700) @(negedge clk);
        chk_s("R9", "lines before stop", ls_cnt - ls0, 2);
        chk_s("R3", "gate width", tgw_seen, 7);
        chk_s("R6", "last pixel index", pmax, 59);
        chk_s("R9", "idle after stop rg_o", int'(rg_o), 0);

        // illegal configurations
        apply_reset(6, 3, 7, PIX_MIN - 1);
        chk_s("R1", "short line err_o", int'(err_o), 1);
        ls0 = ls_cnt;
        pulse_start();
        repeat (40) @(negedge clk);
        chk_s("R1", "start under error lines", ls_cnt - ls0, 0);
        chk_s("R1", "start under error rg_o", int'(rg_o), 0);
        apply_reset(RG_W + CLB_GAP + CLB_W - 1, 3, 7, 60);
        chk_s("R1", "small divider err_o", int'(err_o), 1);
        apply_reset(6, 0, 7, 60);
        chk_s("R1", "zero guard err_o", int'(err_o), 1);
        apply_reset(6, 3, 0, 60);
        chk_s("R1", "zero gate err_o", int'(err_o), 1);

        // boundary configuration, back-to-back lines
        apply_reset(RG_W + CLB_GAP + CLB_W, 1, 1, PIX_MIN);
        chk_s("R1", "minimum cfg err_o", int'(err_o), 0);
        ls0 = ls_cnt;
        pulse_start();
        repeat (500) @(negedge clk);
        pulse_stop();
        repeat (400) @(negedge clk);
        chk_s("R9", "back-to-back lines", ls_cnt - ls0, 3);
        chk_s("R3", "single-clock gate", tgw_seen, 1);
        chk_s("R2", "final idle phi1_o", int'(phi1_o), 1);

        $display("  CHECKS %0d ERRORS %0d", cyc_checks + s_checks, cyc_errors + s_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", cyc_checks + s_checks + 1, cyc_errors + s_errors + 1);
        $finish;
    end

endmodule